// File: doc/BRIEF.md
# Page-Mode DRAM Controller

This block sits between a synchronous host and an asynchronous 1M x 16 dynamic RAM whose address pins are shared between row and column. The host gives a 20-bit word address, a read/write flag, two byte enables and write data on a valid/ready channel. The controller splits the address into a 12-bit row (upper bits) and an 8-bit column (lower bits). It drives the row strobe, two byte-lane column strobes, write enable, output enable and the shared address bus. It returns read words on a one-cycle valid pulse. All DRAM timing limits are parameters in nanoseconds. They are turned into clock counts by rounding up the ratio to the clock period.

After an access the row stays open. A later request to the same row strobes only a new column, so a page hit costs one short column cycle. A request to another row first closes the open one. The row is also closed when a refresh block asks for the memory, and before the row strobe has been low for the longest time allowed. Closing always waits out the minimum row-active time, and the precharge time follows before the next row opens. Writes are always early writes: write enable falls before the column strobe, and output enable stays high.

The DQ bus is brought out as separate input, output and output-enable pins; the tristate buffer sits in the pad ring.

Top module: `fpm_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, ras_n, lcas_n, ucas_n, we_n and oe_n are high, dq_oe, ref_gnt and rd_valid are low.
- R2: For request address addr, bits [19:8] are on dram_a when ras_n falls, and bits [7:0] are on dram_a[7:0] (with dram_a[11:8] zero) when a column strobe falls. Each address stays stable across its strobe edge, so data written to addr reads back from addr.
- R3: A request whose row equals the open row strobes only the column: ras_n does not rise or fall for it, even after the row has sat idle.
- R4: A request to a different row raises ras_n, keeps it high at least RP cycles, then opens the new row.
- R5: A column strobe falls no sooner than RCD cycles after ras_n falls. It stays low at least CAS cycles and high at least CP cycles between two column accesses in one row. It is never low while ras_n is high.
- R6: Each low period of ras_n lasts at least RAS and at most RASMAX cycles. When a stream of same-row requests would exceed RASMAX, the controller closes and reopens the row itself.
- R7: Byte enable bit 0 selects lcas_n (DQ[7:0]) and bit 1 selects ucas_n (DQ[15:8]); only the selected strobes fall, for both reads and writes.
- R8: On a write, we_n is low at least one cycle before the column strobe falls, oe_n stays high and dq_oe is high. On a read, we_n is high, oe_n falls with the column strobe and dq_oe is low. dq_oe and a low oe_n never coincide.
- R9: Each read gives exactly one single-cycle rd_valid pulse, in request order. rd_data holds the DQ word sampled in the last cycle of the column strobe, with disabled bytes returned as zero.
- R10: ref_gnt rises only after the row is closed and precharged. While it is high, all strobes stay high and req_ready is low. It falls in the cycle after ref_req falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request taken on this edge when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Word address, row in [19:8], column in [7:0] |
| req_be | input | 2 | Byte enables, bit 0 low byte |
| req_wdata | input | 16 | Write data |
| rd_valid | output | 1 | One-cycle read-return pulse |
| rd_data | output | 16 | Read word |
| ref_req | input | 1 | Refresh block asks for the memory |
| ref_gnt | output | 1 | Memory parked and handed to refresh block |
| ras_n | output | 1 | Row strobe, active low |
| lcas_n | output | 1 | Low-byte column strobe, active low |
| ucas_n | output | 1 | High-byte column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| oe_n | output | 1 | Output enable, active low |
| dram_a | output | 12 | Multiplexed row/column address |
| dq_out | output | 16 | Write data to DQ pads |
| dq_oe | output | 1 | DQ pad output enable |
| dq_in | input | 16 | Data from DQ pads |

## Verification
Every output is a register, so each pin changes one edge after the decision that moves it. A request taken in an idle state shows its row on dram_a one cycle later and ras_n falls one cycle after that. The column strobe follows RCD+1 cycles after ras_n falls. A page hit shows its column one cycle after acceptance and its strobe one cycle later. rd_valid comes at the edge that ends the column strobe, and the ready gap between page hits is CAS+CP+2 cycles. The bench samples all pins at the falling clock edge and measures each low and high run of the strobes in whole cycles against the rounded-up limits. It pairs each column strobe with the oldest accepted request and each rd_valid pulse with the oldest pending read, so a result is judged by order and not by a fixed cycle count.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,  // row closed and precharged
    ST_ROW,   // row address on bus, strobe still high
    ST_RCD,   // row strobe low, waiting for column delay
    ST_COL,   // column address and write controls set up
    ST_CAS,   // column strobe low
    ST_CP,    // column strobe precharge
    ST_OPEN,  // row open, waiting for work
    ST_HOLD,  // waiting for minimum row-active time
    ST_PRE,   // row precharge
    ST_GNT    // memory handed to refresh block
  } fpm_st_e;

  function automatic int ns2cyc(input int ns, input int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/fpm_timer.sv
module fpm_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] val,
  output logic         done
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);
endmodule

// File: rtl/fpm_row_age.sv
module fpm_row_age #(
  parameter int RAS_CYC    = 6,
  parameter int RASMAX_CYC = 10000,
  parameter int CAS_CYC    = 2,
  parameter int CP_CYC     = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic ras_n,
  output logic min_met,
  output logic age_hit
);
  localparam int AW    = $clog2(RASMAX_CYC + 1);
  // latest age at which a page hit can still finish and the row close in time
  localparam int LIMIT = RASMAX_CYC - 4 - CAS_CYC - CP_CYC;
  localparam logic [AW-1:0] MIN_V = AW'(RAS_CYC - 1);
  localparam logic [AW-1:0] LIM_V = AW'(LIMIT);
  localparam logic [AW-1:0] MAX_V = AW'(RASMAX_CYC);

  logic [AW-1:0] age;

  always_ff @(posedge clk) begin
    if (rst || ras_n)    age <= '0;
    else if (age != '1)  age <= age + 1'b1;
  end

  assign min_met = ras_n || (age >= MIN_V);
  assign age_hit = !ras_n && (age > LIM_V);

  // R6
  age_cap_chk: assert property (@(posedge clk) disable iff (rst)
    !ras_n |-> (age < MAX_V));
endmodule

// File: rtl/fpm_rd_capture.sv
module fpm_rd_capture #(
  parameter int DQ_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap,
  input  logic [DQ_W/8-1:0] be,
  input  logic [DQ_W-1:0]   dq_in,
  output logic              rd_valid,
  output logic [DQ_W-1:0]   rd_data
);
  localparam int NB = DQ_W / 8;

  always_ff @(posedge clk) begin
    if (rst) rd_valid <= 1'b0;
    else     rd_valid <= cap;
  end

  for (genvar b = 0; b < NB; b++) begin : g_byte
    always_ff @(posedge clk) begin
      if (rst)      rd_data[8*b +: 8] <= '0;
      else if (cap) rd_data[8*b +: 8] <= be[b] ? dq_in[8*b +: 8] : 8'h00;
    end
  end

  // R9
  rd_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid);
endmodule

// File: rtl/fpm_ctrl.sv
module fpm_ctrl #(
  parameter int CLK_NS    = 10,
  parameter int ROW_W     = 12,
  parameter int COL_W     = 8,
  parameter int DQ_W      = 16,
  parameter int RCD_NS    = 20,
  parameter int CAS_NS    = 15,
  parameter int CP_NS     = 10,
  parameter int RP_NS     = 40,
  parameter int RAS_NS    = 60,
  parameter int RASMAX_NS = 100000
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_write,
  input  logic [ROW_W+COL_W-1:0] req_addr,
  input  logic [DQ_W/8-1:0]      req_be,
  input  logic [DQ_W-1:0]        req_wdata,
  output logic                   rd_valid,
  output logic [DQ_W-1:0]        rd_data,
  input  logic                   ref_req,
  output logic                   ref_gnt,
  output logic                   ras_n,
  output logic                   lcas_n,
  output logic                   ucas_n,
  output logic                   we_n,
  output logic                   oe_n,
  output logic [ROW_W-1:0]       dram_a,
  output logic [DQ_W-1:0]        dq_out,
  output logic                   dq_oe,
  input  logic [DQ_W-1:0]        dq_in
);
  import fpm_pkg::*;

  localparam int ADDR_W     = ROW_W + COL_W;
  localparam int BE_W       = DQ_W / 8;
  localparam int RCD_CYC    = ns2cyc(RCD_NS, CLK_NS);
  localparam int CAS_CYC    = ns2cyc(CAS_NS, CLK_NS);
  localparam int CP_CYC     = ns2cyc(CP_NS, CLK_NS);
  localparam int RP_CYC     = ns2cyc(RP_NS, CLK_NS);
  localparam int RAS_CYC    = ns2cyc(RAS_NS, CLK_NS);
  localparam int RASMAX_CYC = ns2cyc(RASMAX_NS, CLK_NS);
  localparam int T_MAX      = imax(imax(RCD_CYC, CAS_CYC), imax(CP_CYC, RP_CYC));
  localparam int TW         = $clog2(T_MAX + 1);
  localparam logic [TW-1:0] RCD_LD = TW'(RCD_CYC - 1);
  localparam logic [TW-1:0] CAS_LD = TW'(CAS_CYC - 1);
  localparam logic [TW-1:0] CP_LD  = TW'(CP_CYC - 1);
  localparam logic [TW-1:0] RP_LD  = TW'(RP_CYC - 1);

  fpm_st_e st, nxt;

  logic              t_load, t_done;
  logic [TW-1:0]     t_val;
  logic              min_met, age_hit;
  logic              accept, same_row, pend, cap;
  logic [ROW_W-1:0]  row_q;
  logic              h_wr;
  logic [ADDR_W-1:0] h_addr;
  logic [BE_W-1:0]   h_be;
  logic [DQ_W-1:0]   h_wdata;

  fpm_timer #(.W(TW)) u_timer (
    .clk (clk), .rst (rst), .load (t_load), .val (t_val), .done (t_done)
  );

  fpm_row_age #(
    .RAS_CYC (RAS_CYC), .RASMAX_CYC (RASMAX_CYC),
    .CAS_CYC (CAS_CYC), .CP_CYC (CP_CYC)
  ) u_age (
    .clk (clk), .rst (rst), .ras_n (ras_n),
    .min_met (min_met), .age_hit (age_hit)
  );

  assign cap = (st == ST_CAS) && t_done && !h_wr;

  fpm_rd_capture #(.DQ_W(DQ_W)) u_cap (
    .clk (clk), .rst (rst), .cap (cap), .be (h_be), .dq_in (dq_in),
    .rd_valid (rd_valid), .rd_data (rd_data)
  );

  assign same_row  = (req_addr[ADDR_W-1:COL_W] == row_q);
  assign req_ready = !ref_req &&
                     ((st == ST_IDLE) || ((st == ST_OPEN) && !age_hit));
  assign accept    = req_valid && req_ready;

  always_comb begin
    nxt = st;
    unique case (st)
      ST_IDLE: if (ref_req) nxt = ST_GNT;
               else if (accept) nxt = ST_ROW;
      ST_ROW:  nxt = ST_RCD;
      ST_RCD:  if (t_done) nxt = ST_COL;
      ST_COL:  nxt = ST_CAS;
      ST_CAS:  if (t_done) nxt = ST_CP;
      ST_CP:   if (t_done) nxt = ST_OPEN;
      ST_OPEN: if (ref_req || age_hit) nxt = ST_HOLD;
               else if (accept) nxt = same_row ? ST_COL : ST_HOLD;
      ST_HOLD: if (min_met) nxt = ST_PRE;
      ST_PRE:  if (t_done) nxt = ref_req ? ST_GNT : (pend ? ST_ROW : ST_IDLE);
      ST_GNT:  if (!ref_req) nxt = ST_PRE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_comb begin
    t_load = (nxt != st);
    unique case (nxt)
      ST_RCD:  t_val = RCD_LD;
      ST_CAS:  t_val = CAS_LD;
      ST_CP:   t_val = CP_LD;
      ST_PRE:  t_val = RP_LD;
      default: t_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      ras_n   <= 1'b1;
      lcas_n  <= 1'b1;
      ucas_n  <= 1'b1;
      we_n    <= 1'b1;
      oe_n    <= 1'b1;
      dram_a  <= '0;
      dq_out  <= '0;
      dq_oe   <= 1'b0;
      ref_gnt <= 1'b0;
      pend    <= 1'b0;
      row_q   <= '0;
      h_wr    <= 1'b0;
      h_addr  <= '0;
      h_be    <= '0;
      h_wdata <= '0;
    end else begin
      st <= nxt;
      if (accept) begin
        h_wr    <= req_write;
        h_addr  <= req_addr;
        h_be    <= req_be;
        h_wdata <= req_wdata;
        if (!((st == ST_OPEN) && same_row)) pend <= 1'b1;
      end
      unique case (st)
        ST_IDLE: begin
          if (nxt == ST_ROW) dram_a <= req_addr[ADDR_W-1:COL_W];
          if (nxt == ST_GNT) ref_gnt <= 1'b1;
        end
        ST_ROW: begin
          ras_n <= 1'b0;
          row_q <= h_addr[ADDR_W-1:COL_W];
          pend  <= 1'b0;
        end
        ST_RCD: if (nxt == ST_COL) begin
          dram_a <= {{(ROW_W-COL_W){1'b0}}, h_addr[COL_W-1:0]};
          we_n   <= !h_wr;
          dq_out <= h_wdata;
          dq_oe  <= h_wr;
        end
        ST_COL: begin
          lcas_n <= !h_be[0];
          ucas_n <= !h_be[1];
          oe_n   <= h_wr;
        end
        ST_CAS: if (nxt == ST_CP) begin
          lcas_n <= 1'b1;
          ucas_n <= 1'b1;
          oe_n   <= 1'b1;
          we_n   <= 1'b1;
          dq_oe  <= 1'b0;
        end
        ST_OPEN: if (nxt == ST_COL) begin
          dram_a <= {{(ROW_W-COL_W){1'b0}}, req_addr[COL_W-1:0]};
          we_n   <= !req_write;
          dq_out <= req_wdata;
          dq_oe  <= req_write;
        end
        ST_HOLD: if (nxt == ST_PRE) ras_n <= 1'b1;
        ST_PRE: begin
          if (nxt == ST_ROW) dram_a <= h_addr[ADDR_W-1:COL_W];
          if (nxt == ST_GNT) ref_gnt <= 1'b1;
        end
        ST_GNT: if (nxt == ST_PRE) ref_gnt <= 1'b0;
        default: ;
      endcase
    end
  end

  // R10
  gnt_idle_chk: assert property (@(posedge clk) disable iff (rst)
    ref_gnt |-> (ras_n && lcas_n && ucas_n && !req_ready));

  // R5
  cas_in_row_chk: assert property (@(posedge clk) disable iff (rst)
    (!lcas_n || !ucas_n) |-> !ras_n);

  // R8
  early_we_chk: assert property (@(posedge clk) disable iff (rst)
    (($fell(lcas_n) || $fell(ucas_n)) && !we_n) |-> (!$past(we_n) && oe_n && dq_oe));

  // R8
  no_drive_fight_chk: assert property (@(posedge clk) disable iff (rst)
    dq_oe |-> oe_n);

  // R2
  row_stable_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(ras_n) |-> $stable(dram_a));

  // R2
  col_stable_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(lcas_n) || $fell(ucas_n)) |-> $stable(dram_a));
endmodule

// File: tb/sim_fpm_ctrl.sv
module sim_fpm_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int RASMAX_NS  = 2500;
  localparam int RCD_C    = (20 + CLK_PERIOD - 1) / CLK_PERIOD;
  localparam int CAS_C    = (15 + CLK_PERIOD - 1) / CLK_PERIOD;
  localparam int CP_C     = (10 + CLK_PERIOD - 1) / CLK_PERIOD;
  localparam int RP_C     = (40 + CLK_PERIOD - 1) / CLK_PERIOD;
  localparam int RAS_C    = (60 + CLK_PERIOD - 1) / CLK_PERIOD;
  localparam int RASMAX_C = (RASMAX_NS + CLK_PERIOD - 1) / CLK_PERIOD;

  logic clk = 0, rst = 1;
  logic req_valid = 0, req_write = 0;
  logic [19:0] req_addr = '0;
  logic [1:0]  req_be = '0;
  logic [15:0] req_wdata = '0;
  logic ref_req = 0;
  logic [15:0] dq_in = 16'hA5A5;
  logic req_ready, rd_valid, ref_gnt, ras_n, lcas_n, ucas_n, we_n, oe_n, dq_oe;
  logic [15:0] rd_data, dq_out;
  logic [11:0] dram_a;

  always #(CLK_PERIOD/2) clk = ~clk;

  fpm_ctrl #(.CLK_NS(CLK_PERIOD), .RASMAX_NS(RASMAX_NS)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_be(req_be),
    .req_wdata(req_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
    .ref_req(ref_req), .ref_gnt(ref_gnt), .ras_n(ras_n), .lcas_n(lcas_n),
    .ucas_n(ucas_n), .we_n(we_n), .oe_n(oe_n), .dram_a(dram_a),
    .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  typedef struct { bit wr; logic [19:0] addr; logic [1:0] be; logic [15:0] d; } acc_t;
  acc_t aq[$];
  logic [15:0] rq[$];
  logic [15:0] sh [int];   // shadow of host view
  logic [15:0] mm [int];   // memory array of the pin-level model

  // pin-level DRAM model and timing monitor
  int ras_low = 0, ras_high = 1000, cas_low = 0, cas_high = 1000, ras_falls = 0;
  bit first_cas = 0;
  logic p_ras = 1, p_any = 0, p_we = 1;
  logic [11:0] mrow = '0;

  always @(negedge clk) begin
    if (!rst) begin : mon
      logic any;
      int key;
      logic [15:0] w;
      acc_t a;
      any = !lcas_n || !ucas_n;
      if (p_ras && !ras_n) begin
        ras_falls++; mrow = dram_a; first_cas = 1;
        chk(ras_high >= RP_C, "R4", "precharge cycles", ras_high, RP_C);
        ras_low = 0;
      end
      if (!p_ras && ras_n) begin
        chk(ras_low >= RAS_C && ras_low <= RASMAX_C, "R6", "row low cycles", ras_low, RASMAX_C);
        ras_high = 0;
      end
      if (!ras_n) ras_low++; else ras_high++;
      if (any) chk(!ras_n, "R5", "cas with row closed", ras_n, 0);
      if (!p_any && any) begin
        if (first_cas) chk(ras_low - 1 >= RCD_C, "R5", "ras-to-cas", ras_low - 1, RCD_C);
        else           chk(cas_high >= CP_C, "R5", "cas precharge", cas_high, CP_C);
        first_cas = 0; cas_low = 0;
        if (aq.size() == 0) chk(0, "R2", "column strobe with no request", 0, 1);
        else begin
          a = aq.pop_front();
          chk(mrow == a.addr[19:8], "R2", "row", mrow, a.addr[19:8]);
          chk(dram_a == {4'h0, a.addr[7:0]}, "R2", "column", dram_a, a.addr[7:0]);
          chk({!ucas_n, !lcas_n} == a.be, "R7", "byte strobes", {!ucas_n, !lcas_n}, a.be);
          key = int'({mrow, dram_a[7:0]});
          w = mm.exists(key) ? mm[key] : 16'h0000;
          if (a.wr) begin
            chk(!we_n && !p_we && oe_n && dq_oe, "R8", "early write pins",
                {we_n, p_we, oe_n, dq_oe}, 4'b0011);
            if (!lcas_n) w[7:0]  = dq_out[7:0];
            if (!ucas_n) w[15:8] = dq_out[15:8];
            mm[key] = w;
          end else begin
            chk(we_n && !oe_n && !dq_oe, "R8", "read pins", {we_n, oe_n, dq_oe}, 3'b100);
            dq_in = {(!ucas_n ? w[15:8] : 8'hA5), (!lcas_n ? w[7:0] : 8'hA5)};
          end
        end
      end
      if (p_any && !any) begin
        chk(cas_low >= CAS_C, "R5", "cas low cycles", cas_low, CAS_C);
        cas_high = 0; dq_in = 16'hA5A5;
      end
      if (any) cas_low++; else cas_high++;
      if (dq_oe) chk(oe_n, "R8", "bus fight", oe_n, 1);
      if (rd_valid) begin
        if (rq.size() == 0) chk(0, "R9", "unexpected rd_valid", 1, 0);
        else begin
          w = rq.pop_front();
          chk(rd_data == w, "R9", "read data", rd_data, w);
        end
      end
      if (ref_gnt) chk(ras_n && lcas_n && ucas_n && !req_ready, "R10", "parked pins",
                       {ras_n, lcas_n, ucas_n, req_ready}, 4'b1110);
      p_ras = ras_n; p_any = any; p_we = we_n;
    end
  end

  task automatic issue(input bit wr, input logic [19:0] ad,
                       input logic [1:0] be, input logic [15:0] d);
    acc_t a;
    logic [15:0] w;
    req_write = wr; req_addr = ad; req_be = be; req_wdata = d; req_valid = 1;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    a.wr = wr; a.addr = ad; a.be = be; a.d = d;
    aq.push_back(a);
    w = sh.exists(int'(ad)) ? sh[int'(ad)] : 16'h0000;
    if (wr) begin
      if (be[0]) w[7:0]  = d[7:0];
      if (be[1]) w[15:8] = d[15:8];
      sh[int'(ad)] = w;
    end else
      rq.push_back({be[1] ? w[15:8] : 8'h00, be[0] ? w[7:0] : 8'h00});
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic drain();
    for (int i = 0; i < 200 && (aq.size() != 0 || rq.size() != 0); i++) @(negedge clk);
    chk(aq.size() == 0 && rq.size() == 0, "R9", "outstanding work", aq.size() + rq.size(), 0);
  endtask

  initial begin : wdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      chk(0, "R1", "watchdog expired", 0, 1);
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : stim
    int f0;
    repeat (2) @(negedge clk);
    // R1: pins parked during reset
    chk(ras_n && lcas_n && ucas_n && we_n && oe_n && !dq_oe && !ref_gnt && !rd_valid,
        "R1", "reset pins", {ras_n, lcas_n, ucas_n, we_n, oe_n, dq_oe, ref_gnt, rd_valid}, 8'hF8);
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(ras_n && lcas_n && ucas_n && !dq_oe && !rd_valid, "R1", "after reset",
        {ras_n, lcas_n, ucas_n, dq_oe, rd_valid}, 5'b11100);

    // R3: mixed page accesses in one row, one row open only
    f0 = ras_falls;
    issue(1, 20'h01203, 2'b11, 16'h1111);
    issue(1, 20'h01280, 2'b11, 16'h2222);
    issue(1, 20'h012FF, 2'b11, 16'h3333);
    issue(0, 20'h01280, 2'b11, 0);
    issue(1, 20'h01200, 2'b11, 16'h4444);
    issue(0, 20'h012FF, 2'b11, 0);
    issue(0, 20'h01203, 2'b11, 0);
    issue(0, 20'h01200, 2'b11, 0);
    drain();
    chk(ras_falls - f0 == 1, "R3", "row opens in page run", ras_falls - f0, 1);

    // R4: row misses alternate between rows
    f0 = ras_falls;
    issue(1, 20'h7A003, 2'b11, 16'hBEEF);
    issue(0, 20'h01203, 2'b11, 0);
    issue(0, 20'h7A003, 2'b11, 0);
    drain();
    chk(ras_falls - f0 == 3, "R4", "row opens on misses", ras_falls - f0, 3);

    // R7 / R9: byte lanes
    issue(1, 20'h00509, 2'b11, 16'h1234);
    issue(1, 20'h00509, 2'b01, 16'hAAEE);
    issue(0, 20'h00509, 2'b11, 0);
    issue(1, 20'h00509, 2'b10, 16'h7799);
    issue(0, 20'h00509, 2'b11, 0);
    issue(0, 20'h00509, 2'b01, 0);
    issue(0, 20'h00509, 2'b10, 0);
    drain();

    // R3: idle open row is kept
    f0 = ras_falls;
    repeat (30) @(negedge clk);
    issue(0, 20'h00509, 2'b11, 0);
    drain();
    chk(ras_falls == f0, "R3", "idle row reused", ras_falls - f0, 0);

    // R10: refresh handoff from an open row
    ref_req = 1;
    for (int i = 0; i < 100 && !ref_gnt; i++) @(negedge clk);
    chk(ref_gnt, "R10", "grant given", ref_gnt, 1);
    chk(ras_high >= RP_C, "R10", "precharged at grant", ras_high, RP_C);
    repeat (10) @(negedge clk);
    chk(ref_gnt, "R10", "grant held", ref_gnt, 1);
    ref_req = 0;
    @(negedge clk);
    chk(!ref_gnt, "R10", "grant released", ref_gnt, 0);

    // R6: long same-row stream forces a close before the limit
    f0 = ras_falls;
    for (int i = 0; i < 80; i++) issue(0, 20'h01200 | 20'(i % 4), 2'b11, 0);
    drain();
    chk(ras_falls - f0 >= 2, "R6", "row reopened in stream", ras_falls - f0, 2);

    // R2: top corner of the address space
    issue(1, 20'hFFFFF, 2'b11, 16'hC3A5);
    issue(1, 20'h000FF, 2'b11, 16'h5A5A);
    issue(0, 20'hFFFFF, 2'b11, 0);
    issue(0, 20'h000FF, 2'b11, 0);
    drain();

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule